// File: doc/BRIEF.md
# Maskable Interrupt Aggregator with Selectable Output Mode

This block gathers fifteen sticky event flags raised by a network controller core and folds them into a single interrupt request. The core pulses a set strobe for each event. The matching flag then stays high until software clears it by writing a one to its bit. Each flag passes through its own suppression control. On some flags that control is an enable, so the flag counts when the bit is one. On the others it is a mask, so the flag counts when the bit is zero. Which flags use which meaning is fixed by a parameter.

The request leaves the block as an output-enable and a drive value, ready for a pad. With the mode bit at zero, the request is an active-low level. The enable pulls the pin low for as long as any qualified flag is set, and the pin floats otherwise, in open-drain style. With the mode bit at one, the pin is driven all the time and carries a one-clock high pulse each time the OR of the qualified flags goes from zero to one. While reset is asserted the pin is never driven, because the pad is then used as a test input.

Flag bit map, as seen on every 15-bit port:

| Bit | Flag | Bit | Flag |
|-----|------|-----|------|
| 0 | receive | 8 | excessive deferral |
| 1 | transmit | 9 | sleep |
| 2 | init done | 10 | wake packet |
| 3 | transmit start | 11 | missed-count overflow |
| 4 | missed frame | 12 | receive-collision-count overflow |
| 5 | memory error | 13 | system error |
| 6 | babble | 14 | user |
| 7 | jabber | | |

Top module: `irq_aggregator`

## Requirements
- R1: While `rst_n` is low, `irq_oe` and `irq_lvl` are 0 and `flags_o` reads 0. This holds even if set strobes are active.
- R2: A one on `set_stb[i]` makes `flags_o[i]` read 1 after the next rising clock edge. The flag stays 1 until it is cleared.
- R3: When `clr_wr` is 1, every bit of `clr_data` that is 1 clears its flag at the next edge. Bits of `clr_data` that are 0 have no effect. When `clr_wr` is 0, `clr_data` has no effect at all.
- R4: If a flag is set and cleared in the same cycle, the set wins and the flag reads 1.
- R5: With the default parameter, bits 8 to 13 use enable semantics: the flag counts toward the request when `supp[i]`=1. Bits 0 to 7 and bit 14 use mask semantics: the flag counts when `supp[i]`=0. So `supp`=15'h3F00 passes every flag and `supp`=15'h40FF blocks every flag.
- R6: In level mode (`edge_mode`=0), `irq_lvl` is 0. `irq_oe` is 1 one clock after a qualified flag is present, and 0 one clock after none is present.
- R7: A change of `supp` shows on `irq_oe` after the next rising clock edge.
- R8: In edge mode (`edge_mode`=1), `irq_oe` is 1 whenever reset is inactive. `irq_lvl` is high for exactly one clock, one clock after the OR of qualified flags rises. It stays low while that OR remains 1, even when more flags arrive.
- R9: In edge mode a new pulse follows each fresh rise of the qualified OR. The OR can fall because flags were cleared or because they were suppressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| set_stb | input | 15 | Per-flag set strobes from the core |
| clr_wr | input | 1 | Software write strobe for the clear register |
| clr_data | input | 15 | Write-one-to-clear data |
| supp | input | 15 | Per-flag suppression bits (mask or enable, see R5) |
| edge_mode | input | 1 | 0: active-low level request, 1: active-high pulse |
| flags_o | output | 15 | Current flag state |
| irq_oe | output | 1 | Pin output enable |
| irq_lvl | output | 1 | Value driven on the pin when enabled |

## Verification
The bench checks four corner cases. The first is a set and a clear of the same flag in one cycle; a design where the clear wins would drop the flag. The second is a clear write whose strobe is low; a design that ignores `clr_wr` would wipe the flag. The third is an enable-type flag and a mask-type flag under the same `supp` word; a design that inverts the polarity per bit wrongly would raise or hold the request in the wrong rows. The fourth covers edge mode: a second flag arriving while the OR is already high must not produce a second pulse, and both clearing and suppressing the flags must re-arm the pulse. The bench also asserts reset in the middle of a run to show that the pin is released at once.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NFLAG = 15;
  // 1 = enable semantics (counts when suppression bit is 1), 0 = mask semantics
  localparam logic [NFLAG-1:0] ENA_SEM_DEFAULT = 15'h3F00;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_stb,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_data,
  output logic [N-1:0] flags_q
);
  logic [N-1:0] clr_eff;
  logic [N-1:0] flags_d;
  logic         flag_en;

  // next-state: clear first, then set so a same-cycle set wins
  always_comb begin
    clr_eff = clr_wr ? clr_data : '0;
    flags_d = (flags_q & ~clr_eff) | set_stb;
    flag_en = |(clr_eff | set_stb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= '0;
    else if (flag_en) flags_q <= flags_d;
  end

  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_stb) |=> ((flags_q & $past(set_stb)) == $past(set_stb)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(flags_q & ~clr_eff)) == $past(flags_q & ~clr_eff)));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(clr_eff & ~set_stb)) == '0));

  assert_set_beats_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && |(clr_data & set_stb)) |=>
      ((flags_q & $past(clr_data & set_stb)) == $past(clr_data & set_stb)));
endmodule

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int            N       = 15,
  parameter logic [N-1:0]  ENA_SEM = '0
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] supp,
  output logic         any_active
);
  logic [N-1:0] pass;

  for (genvar i = 0; i < N; i++) begin : g_qual
    if (ENA_SEM[i]) begin : g_enable
      assign pass[i] = flags[i] & supp[i];
    end else begin : g_mask
      assign pass[i] = flags[i] & ~supp[i];
    end
  end

  assign any_active = |pass;
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic any_active,
  input  logic edge_mode,
  output logic irq_oe,
  output logic irq_lvl
);
  logic any_q, any_d;
  logic pulse_q, pulse_d;

  always_comb begin
    any_d   = any_active;
    pulse_d = any_active & ~any_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      any_q   <= any_d;
      pulse_q <= pulse_d;
    end
  end

  assign irq_oe  = rst_n & (edge_mode | any_q);
  assign irq_lvl = rst_n & edge_mode & pulse_q;

  always_comb begin
    if (!rst_n) begin
      assert_quiet_in_reset_R1: assert (!irq_oe && !irq_lvl);
    end
  end

  assert_level_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && any_active) |=> irq_oe);

  assert_level_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && !any_active) |=> (edge_mode || !irq_oe));

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lvl |=> !irq_lvl);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int                 NFLAG   = irq_agg_pkg::NFLAG,
  parameter logic [NFLAG-1:0]   ENA_SEM = irq_agg_pkg::ENA_SEM_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_stb,
  input  logic             clr_wr,
  input  logic [NFLAG-1:0] clr_data,
  input  logic [NFLAG-1:0] supp,
  input  logic             edge_mode,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_oe,
  output logic             irq_lvl
);
  logic rst_n_s;
  logic any_active;

  irq_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  irq_flag_bank #(.N(NFLAG)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .set_stb  (set_stb),
    .clr_wr   (clr_wr),
    .clr_data (clr_data),
    .flags_q  (flags_o)
  );

  irq_qualify #(.N(NFLAG), .ENA_SEM(ENA_SEM)) u_qual (
    .flags      (flags_o),
    .supp       (supp),
    .any_active (any_active)
  );

  irq_pin_drive u_pin (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .any_active (any_active),
    .edge_mode  (edge_mode),
    .irq_oe     (irq_oe),
    .irq_lvl    (irq_lvl)
  );
endmodule

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
  localparam int N = 15;
  localparam logic [N-1:0] PASS_ALL  = 15'h3F00;
  localparam logic [N-1:0] BLOCK_ALL = 15'h40FF;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] set_stb, clr_data, supp;
  logic clr_wr, edge_mode;
  logic [N-1:0] flags_o;
  logic irq_oe, irq_lvl;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  irq_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .clr_wr(clr_wr),
    .clr_data(clr_data), .supp(supp), .edge_mode(edge_mode),
    .flags_o(flags_o), .irq_oe(irq_oe), .irq_lvl(irq_lvl)
  );

  // row: {set[61:47], wr[46], data[45:31], supp[30:16], exp_flags[15:1], exp_oe[0]}
  localparam int NV = 15;
  localparam logic [61:0] VEC [NV] = '{
    {15'h0001, 1'b0, 15'h0000, 15'h3F00, 15'h0001, 1'b0}, // R2 set rx
    {15'h0000, 1'b0, 15'h0000, 15'h3F00, 15'h0001, 1'b1}, // R6 request rises
    {15'h0000, 1'b0, 15'h0000, 15'h40FF, 15'h0001, 1'b0}, // R7 mask all
    {15'h0000, 1'b0, 15'h0000, 15'h40FE, 15'h0001, 1'b1}, // R5 unmask bit 0
    {15'h0200, 1'b0, 15'h0000, 15'h40FF, 15'h0201, 1'b0}, // R5 sleep, enable off
    {15'h0000, 1'b0, 15'h0000, 15'h42FF, 15'h0201, 1'b1}, // R5 enable bit 9
    {15'h0000, 1'b1, 15'h0001, 15'h42FF, 15'h0200, 1'b1}, // R3 clear bit 0
    {15'h0200, 1'b1, 15'h0200, 15'h42FF, 15'h0200, 1'b1}, // R4 set wins
    {15'h0000, 1'b1, 15'h0200, 15'h42FF, 15'h0000, 1'b1}, // R3 clear bit 9
    {15'h0000, 1'b0, 15'h0000, 15'h42FF, 15'h0000, 1'b0}, // R6 request drops
    {15'h4000, 1'b0, 15'h7FFF, 15'h3F00, 15'h4000, 1'b0}, // R3 wr low, user set
    {15'h0000, 1'b0, 15'h7FFF, 15'h3F00, 15'h4000, 1'b1}, // R3 wr low ignored
    {15'h0000, 1'b1, 15'h0000, 15'h3F00, 15'h4000, 1'b1}, // R3 zero bits ignored
    {15'h0000, 1'b1, 15'h4000, 15'h3F00, 15'h0000, 1'b1}, // R3 clear user
    {15'h0000, 1'b0, 15'h0000, 15'h3F00, 15'h0000, 1'b0}  // R6 idle
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [N-1:0] s, input logic w, input logic [N-1:0] d);
    set_stb = s; clr_wr = w; clr_data = d;
  endtask

  initial begin
    rst_n = 1'b0; edge_mode = 1'b0; supp = PASS_ALL;
    drive('0, 1'b0, '0);
    repeat (2) @(negedge clk);
    set_stb = '1;
    repeat (2) @(negedge clk);
    chk("R1 oe in reset", 32'(irq_oe), 0);
    chk("R1 lvl in reset", 32'(irq_lvl), 0);
    chk("R1 flags in reset", 32'(flags_o), 0);
    set_stb = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 idle after reset", 32'(irq_oe), 0);

    // vector table, level mode
    for (int i = 0; i < NV; i++) begin
      set_stb  = VEC[i][61:47];
      clr_wr   = VEC[i][46];
      clr_data = VEC[i][45:31];
      supp     = VEC[i][30:16];
      tick();
      chk($sformatf("R2-R7 row %0d flags", i), 32'(flags_o), 32'(VEC[i][15:1]));
      chk($sformatf("R6 row %0d oe", i), 32'(irq_oe), 32'(VEC[i][0]));
      chk($sformatf("R6 row %0d lvl", i), 32'(irq_lvl), 0);
      drive('0, 1'b0, '0);
    end

    // edge mode
    supp = PASS_ALL; edge_mode = 1'b1;
    @(negedge clk);
    chk("R8 oe in edge mode", 32'(irq_oe), 1);
    chk("R8 no pulse idle", 32'(irq_lvl), 0);
    drive(15'h0002, 1'b0, '0); tick(); drive('0, 1'b0, '0);
    chk("R8 flag set no pulse yet", 32'(irq_lvl), 0);
    tick();
    chk("R8 pulse high", 32'(irq_lvl), 1);
    tick();
    chk("R8 pulse one clock", 32'(irq_lvl), 0);
    drive(15'h0004, 1'b0, '0); tick(); drive('0, 1'b0, '0);
    tick();
    chk("R8 no pulse for second flag", 32'(irq_lvl), 0);
    chk("R8 oe held", 32'(irq_oe), 1);
    drive('0, 1'b1, 15'h0006); tick(); drive('0, 1'b0, '0);
    chk("R9 flags cleared", 32'(flags_o), 0);
    tick();
    chk("R9 no pulse on fall", 32'(irq_lvl), 0);
    drive(15'h0008, 1'b0, '0); tick(); drive('0, 1'b0, '0);
    tick();
    chk("R9 re-pulse after clear", 32'(irq_lvl), 1);
    supp = BLOCK_ALL; tick();
    chk("R9 suppressed no pulse", 32'(irq_lvl), 0);
    supp = PASS_ALL; tick();
    chk("R9 re-pulse after unmask", 32'(irq_lvl), 1);
    tick();
    chk("R9 pulse ends", 32'(irq_lvl), 0);

    // mid-run reset
    #1 rst_n = 1'b0;
    #1;
    chk("R1 oe released at reset", 32'(irq_oe), 0);
    chk("R1 flags cleared at reset", 32'(flags_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R8 oe back after reset", 32'(irq_oe), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule